// File: doc/BRIEF.md
# Memory Word Poll Engine

This block is a bus-master wait primitive. A client hands it a byte address, a condition (equal or not-equal), a comparison operand and a poll spacing in clock cycles. The engine then reads that one memory word again and again over a single-beat read channel of the AXI4-Lite kind. Each returned word is tested against the operand. When the test holds, the engine reports the exact word it read.

The operand is loaded with each request, so it can be a constant or a value the client read earlier. A typical case is a ring consumer that holds the head index and waits for the tail word to move away from it. The spacing counts from the cycle that accepts a read response, so a slow slave never causes reads to arrive back to back. A spacing of 0 or 1 means the engine keeps the bus busy all the time, and the engine flags this. An abort input stops the wait, but only after any read already on the bus has been answered.

Requests enter through a valid/ready handshake: a request is taken in a cycle where both `req_valid` and `req_ready` are high. While the engine is busy it holds `req_ready` low, and the client may keep `req_valid` asserted without effect. The read channel follows the usual valid/ready rules: the address stays put until the slave accepts it, and a response is taken only while `r_ready` is high. Completion is a one-cycle `done` pulse with no back-pressure.

Top module: `word_poll_engine`

## Requirements
- R1: After reset, `req_ready` is 1 and `ar_valid`, `r_ready`, `done` and `sat_flag` are all 0.
- R2: A request is accepted only when `req_ready` is 1, and `req_ready` stays 0 from acceptance until completion or abort. The first read is presented in the cycle after acceptance. `ar_word` equals the request byte address shifted right by log2(DATA_W/8), which is bits [31:2] at the defaults.
- R3: Once `ar_valid` is 1, it stays 1 with an unchanged `ar_word` until the cycle in which `ar_ready` is 1.
- R4: With `req_cond`=0, the wait ends on the first returned word equal to the operand. With `req_cond`=1, it ends on the first returned word that differs from the operand. Every other word causes another read.
- R5: On completion `done` is 1 for exactly one cycle, two cycles after the satisfying response is accepted. `result` holds that word, `done_err` is 0, and `req_ready` is 1 in the following cycle.
- R6: After a non-matching response is accepted in cycle t, the next `ar_valid` first appears in cycle t+max(I,2), where I is the request interval. No read is presented in between.
- R7: `r_ready` is 1 only while a read is outstanding, from the cycle after the address handshake until the response is accepted.
- R8: A response with a nonzero `r_resp` ends the wait with `done`=1 and `done_err`=1, whatever the data. `result` carries that response's data, and no further read is issued.
- R9: `abort` while no read is outstanding returns the engine to idle in the next cycle with no `done`. `abort` while a read is outstanding or pending lets the address handshake and the response complete, then returns to idle with no `done`.
- R10: `sat_flag` is set when a request with interval 0 or 1 is accepted and stays set through that wait and afterwards. It is cleared only when a request with an interval of 2 or more is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_addr | input | ADDR_W | Byte address of the watched word |
| req_cond | input | 1 | 0: wait for equal, 1: wait for not-equal |
| req_operand | input | DATA_W | Comparison operand |
| req_interval | input | IVL_W | Poll spacing in cycles |
| abort | input | 1 | Stop waiting (drains any outstanding read) |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_word | output | ADDR_W-log2(DATA_W/8) | Word index of the read |
| r_valid | input | 1 | Read response valid |
| r_ready | output | 1 | Read response accepted |
| r_data | input | DATA_W | Read data |
| r_resp | input | RESP_W | Response code, 0 = success |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Completion caused by an error response |
| result | output | DATA_W | Word that ended the wait |
| sat_flag | output | 1 | Polling-bound indication (sticky) |

## Verification
The hardest case to reach is an abort that lands while a read is still in flight. The engine must keep its address stable through the abort, accept the late response even when that word would have matched, and then fall idle without a completion. The stimulus reaches this by raising `abort` in the same cycle the first address appears, while `ar_ready` is held low. It then grants the address a cycle later and returns a matching word. The spacing windows are measured by a slave model that varies its address and response latencies, so the gap is known to be timed from the response and not from the issue.

// File: rtl/wpe_pkg.sv
package wpe_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT_RESP, S_COMPARE, S_WAIT_GAP, S_DONE
  } wpe_state_t;

  typedef enum logic {
    COND_EQ = 1'b0,
    COND_NE = 1'b1
  } wpe_cond_t;
endpackage

// File: rtl/wpe_match.sv
module wpe_match
  import wpe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  wpe_cond_t           cond,
  input  logic [DATA_W-1:0]   word,
  input  logic [DATA_W-1:0]   operand,
  output logic                hit
);
  logic same;
  assign same = (word == operand);
  assign hit  = (cond == COND_EQ) ? same : !same;
endmodule

// File: rtl/wpe_gap_timer.sv
module wpe_gap_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/word_poll_engine.sv
module word_poll_engine
  import wpe_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IVL_W  = 16,
  parameter int RESP_W = 2,
  localparam int OFS_W  = $clog2(DATA_W / 8),
  localparam int WIDX_W = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_cond,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [IVL_W-1:0]  req_interval,
  input  logic              abort,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [WIDX_W-1:0] ar_word,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [RESP_W-1:0] r_resp,
  output logic              done,
  output logic              done_err,
  output logic [DATA_W-1:0] result,
  output logic              sat_flag
);
  localparam logic [IVL_W-1:0] IVL_TWO   = IVL_W'(2);
  localparam logic [IVL_W-1:0] IVL_THREE = IVL_W'(3);

  wpe_state_t        state, nxt;
  logic [WIDX_W-1:0] widx_q;
  wpe_cond_t         cond_q;
  logic [DATA_W-1:0] opnd_q, data_q;
  logic [RESP_W-1:0] resp_q;
  logic [IVL_W-1:0]  ivl_q;
  logic              abort_pend, sat_q;
  logic              hit, gap_zero, gap_load;
  logic              take_req, take_resp, resp_bad;

  assign take_req  = req_valid && req_ready;
  assign take_resp = r_valid && r_ready;
  assign resp_bad  = (resp_q != '0);

  wpe_match #(.DATA_W(DATA_W)) u_match (
    .cond(cond_q), .word(data_q), .operand(opnd_q), .hit(hit)
  );

  assign gap_load = (state == S_COMPARE) && (nxt == S_WAIT_GAP);

  wpe_gap_timer #(.W(IVL_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(ivl_q - IVL_THREE),
    .tick(state == S_WAIT_GAP), .zero(gap_zero)
  );

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:      if (req_valid) nxt = S_ISSUE;
      S_ISSUE:     if (ar_ready) nxt = S_WAIT_RESP;
      S_WAIT_RESP: if (r_valid) nxt = (abort || abort_pend) ? S_IDLE : S_COMPARE;
      S_COMPARE: begin
        if (abort)                  nxt = S_IDLE;
        else if (resp_bad || hit)   nxt = S_DONE;
        else if (ivl_q <= IVL_TWO)  nxt = S_ISSUE;
        else                        nxt = S_WAIT_GAP;
      end
      S_WAIT_GAP: begin
        if (abort)         nxt = S_IDLE;
        else if (gap_zero) nxt = S_ISSUE;
      end
      S_DONE:      nxt = S_IDLE;
      default:     nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      widx_q     <= '0;
      cond_q     <= COND_EQ;
      opnd_q     <= '0;
      ivl_q      <= '0;
      data_q     <= '0;
      resp_q     <= '0;
      abort_pend <= 1'b0;
      sat_q      <= 1'b0;
    end else begin
      state <= nxt;
      if (take_req) begin
        widx_q <= req_addr[ADDR_W-1:OFS_W];
        cond_q <= wpe_cond_t'(req_cond);
        opnd_q <= req_operand;
        ivl_q  <= req_interval;
        sat_q  <= (req_interval <= IVL_W'(1));
      end
      if (take_resp) begin
        data_q <= r_data;
        resp_q <= r_resp;
      end
      if (state == S_IDLE) abort_pend <= 1'b0;
      else if (abort && (state == S_ISSUE || state == S_WAIT_RESP)) abort_pend <= 1'b1;
    end
  end

  assign req_ready = (state == S_IDLE);
  assign ar_valid  = (state == S_ISSUE);
  assign ar_word   = widx_q;
  assign r_ready   = (state == S_WAIT_RESP);
  assign done      = (state == S_DONE);
  assign done_err  = (state == S_DONE) && resp_bad;
  assign result    = data_q;
  assign sat_flag  = sat_q;

  assert_first_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> ar_valid && !req_ready);

  assert_ar_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid && !ar_ready |=> ar_valid && $stable(ar_word));

  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && req_ready);

  assert_gap_from_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_resp |=> !ar_valid);

  assert_rready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    r_ready && !r_valid |=> r_ready);

  assert_err_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COMPARE) && resp_bad && !abort |=> done && done_err);

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort && (state == S_COMPARE || state == S_WAIT_GAP) |=> req_ready && !done);

  assert_sat_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sat_flag) || $fell(sat_flag)) |-> $past(take_req));
endmodule

// File: tb/sim_word_poll_engine.sv
module sim_word_poll_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_cond = 1'b0;
  logic [31:0] req_operand = '0;
  logic [15:0] req_interval = '0;
  logic        abort = 1'b0;
  logic        ar_valid, ar_ready = 1'b0;
  logic [29:0] ar_word;
  logic        r_valid = 1'b0, r_ready;
  logic [31:0] r_data = '0;
  logic [1:0]  r_resp = '0;
  logic        done, done_err, sat_flag;
  logic [31:0] result;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  word_poll_engine u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_cond(req_cond), .req_operand(req_operand),
    .req_interval(req_interval), .abort(abort), .ar_valid(ar_valid),
    .ar_ready(ar_ready), .ar_word(ar_word), .r_valid(r_valid), .r_ready(r_ready),
    .r_data(r_data), .r_resp(r_resp), .done(done), .done_err(done_err),
    .result(result), .sat_flag(sat_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // vector table: cond, operand, interval, misses, miss word, hit word, ar lat, r lat, last resp, addr, noise
  localparam int NV = 6;
  localparam int          T_COND[NV] = '{0, 1, 0, 1, 0, 1};
  localparam logic [31:0] T_OP[NV]   = '{32'h1, 32'h55, 32'hDEAD, 32'h7, 32'h3, 32'h9};
  localparam int          T_IVL[NV]  = '{8, 4, 0, 1, 2, 5};
  localparam int          T_MISS[NV] = '{2, 3, 1, 2, 0, 1};
  localparam logic [31:0] T_MW[NV]   = '{32'h0, 32'h55, 32'h0, 32'h7, 32'h0, 32'h9};
  localparam logic [31:0] T_HW[NV]   = '{32'h1, 32'h56, 32'hDEAD, 32'h0, 32'h3, 32'h1234};
  localparam int          T_ARL[NV]  = '{0, 1, 0, 2, 3, 0};
  localparam int          T_RL[NV]   = '{0, 2, 1, 0, 3, 1};
  localparam int          T_RESP[NV] = '{0, 0, 0, 0, 0, 2};
  localparam logic [31:0] T_ADDR[NV] = '{32'h1000, 32'h2004, 32'h3ff8, 32'h0, 32'h40, 32'h7c};
  localparam int          T_NOISE[NV] = '{1, 0, 0, 0, 0, 0};

  task automatic poll_run(input int v);
    int  reads = 0;
    int  since = -1;
    int  wt = 0;
    int  phase = 0;
    int  ge;
    bit  fin = 0;
    ge = (T_IVL[v] < 2) ? 2 : T_IVL[v];
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 idle before request", 64'(req_ready), 1);
    req_valid = 1'b1; req_cond = T_COND[v][0]; req_operand = T_OP[v];
    req_interval = 16'(T_IVL[v]); req_addr = T_ADDR[v];
    @(negedge clk);
    if (T_NOISE[v] != 0) req_operand = ~T_OP[v];
    else req_valid = 1'b0;
    chk(ar_valid == 1'b1, "R2 first read next cycle", 64'(ar_valid), 1);
    chk(sat_flag == (T_IVL[v] <= 1), "R10 flag at accept", 64'(sat_flag), 64'(T_IVL[v] <= 1));
    for (int k = 0; k < 3000 && !fin; k++) begin
      ar_ready = 1'b0; r_valid = 1'b0; r_resp = '0;
      if (since >= 0) since++;
      if (T_NOISE[v] != 0 && !done)
        chk(req_ready == 1'b0, "R2 busy ignores request", 64'(req_ready), 0);
      if (done) begin
        req_valid = 1'b0;
        chk(since == 2, "R5 done latency", 64'(since), 2);
        chk(reads == T_MISS[v] + 1, "R4 read count", 64'(reads), 64'(T_MISS[v] + 1));
        chk(result == T_HW[v], "R5 result word", 64'(result), 64'(T_HW[v]));
        chk(done_err == (T_RESP[v] != 0), "R8 error status", 64'(done_err), 64'(T_RESP[v] != 0));
        chk(sat_flag == (T_IVL[v] <= 1), "R10 flag sticky", 64'(sat_flag), 64'(T_IVL[v] <= 1));
        fin = 1;
      end else if (phase == 0) begin
        chk(r_ready == 1'b0, "R7 no r_ready without read", 64'(r_ready), 0);
        if (ar_valid) begin
          if (wt == 0) begin
            if (since >= 0) chk(since == ge, "R6 poll spacing", 64'(since), 64'(ge));
            chk(ar_word == T_ADDR[v][31:2], "R2 word index", 64'(ar_word), 64'(T_ADDR[v][31:2]));
            since = -1;
          end else begin
            chk(ar_word == T_ADDR[v][31:2], "R3 address held", 64'(ar_word), 64'(T_ADDR[v][31:2]));
          end
          if (wt == T_ARL[v]) begin ar_ready = 1'b1; phase = 1; wt = 0; end
          else wt++;
        end else if (wt != 0) begin
          chk(1'b0, "R3 ar_valid dropped", 0, 1);
        end
      end else begin
        chk(r_ready == 1'b1, "R7 r_ready while outstanding", 64'(r_ready), 1);
        if (wt == T_RL[v]) begin
          r_valid = 1'b1;
          r_data  = (reads == T_MISS[v]) ? T_HW[v] : T_MW[v];
          r_resp  = (reads == T_MISS[v]) ? 2'(T_RESP[v]) : 2'd0;
          reads++; since = 0; phase = 0; wt = 0;
        end else wt++;
      end
      @(negedge clk);
    end
    ar_ready = 1'b0; r_valid = 1'b0; r_resp = '0; req_valid = 1'b0;
    chk(fin, "R4 wait completed", 64'(fin), 1);
    chk(req_ready == 1'b1 && done == 1'b0, "R5 idle after done", 64'({req_ready, done}), 2);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 reset req_ready", 64'(req_ready), 1);
    chk({ar_valid, r_ready, done, sat_flag} == 4'b0, "R1 reset outputs",
        64'({ar_valid, r_ready, done, sat_flag}), 0);

    for (int v = 0; v < NV; v++) poll_run(v);

    // R9: abort during the interval wait
    @(negedge clk);
    req_valid = 1'b1; req_cond = 1'b0; req_operand = 32'h1; req_interval = 16'd20; req_addr = 32'h100;
    @(negedge clk);
    req_valid = 1'b0; ar_ready = 1'b1;
    @(negedge clk);
    ar_ready = 1'b0; r_valid = 1'b1; r_data = 32'h0;
    @(negedge clk);
    r_valid = 1'b0;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b0 && ar_valid == 1'b0, "R9 still waiting gap", 64'({req_ready, ar_valid}), 0);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(req_ready == 1'b1 && done == 1'b0, "R9 abort in gap idles", 64'({req_ready, done}), 2);

    // R9: abort while the address is still pending, matching response still arrives
    @(negedge clk);
    req_valid = 1'b1; req_cond = 1'b0; req_operand = 32'h1; req_interval = 16'd3; req_addr = 32'h200;
    @(negedge clk);
    req_valid = 1'b0; abort = 1'b1;
    chk(ar_valid == 1'b1, "R9 read pending at abort", 64'(ar_valid), 1);
    @(negedge clk);
    abort = 1'b0;
    chk(ar_valid == 1'b1 && ar_word == 30'h80, "R3 address kept after abort", 64'({ar_valid, ar_word}), 64'({1'b1, 30'h80}));
    ar_ready = 1'b1;
    @(negedge clk);
    ar_ready = 1'b0;
    chk(r_ready == 1'b1, "R9 response still accepted", 64'(r_ready), 1);
    r_valid = 1'b1; r_data = 32'h1;
    @(negedge clk);
    r_valid = 1'b0;
    chk(req_ready == 1'b1 && done == 1'b0, "R9 drained then idle", 64'({req_ready, done}), 2);
    @(negedge clk);
    chk(done == 1'b0 && ar_valid == 1'b0, "R9 no completion after abort", 64'({done, ar_valid}), 0);
    chk(sat_flag == 1'b0, "R10 flag clear with interval 3", 64'(sat_flag), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule